// File: doc/BRIEF.md
# Infrared Transceiver Receiver-Bandwidth Mode Sequencer

This block sits on the host side of an infrared transceiver. It owns the timing of the two control lines that choose the transceiver's receive bandwidth: the shutdown/mode line and the transmit data line. A software or controller agent asks for a bandwidth with a one-bit request on a valid/ready handshake. The value 0 selects the low-rate bandwidth (SIR/MIR, up to 1.152 Mbit/s) and the value 1 selects the high-rate bandwidth (FIR, 4 Mbit/s). The sequencer then raises the shutdown/mode line and places the mode value on the transmit data line. It drops the shutdown/mode line so that the transceiver samples the transmit data line on that falling edge. It holds the value, restores the line, and gives a one-cycle done pulse.

When no sequence is running, the transmit data line is a plain copy of the serial encoder's output. While a sequence runs, the sequencer owns the line and the encoder is ignored. Back-pressure is simple. `req_ready` is high only when the sequencer is idle. A request is taken on a cycle in which `req_valid` and `req_ready` are both high. A requester that holds `req_valid` during a sequence waits and is served in the first idle cycle after done. All delays are parameters in nanoseconds. They are turned into whole clock cycles that strictly exceed each minimum.

Top module: `irxcvr_bw_seq`

## Requirements
- R1: Out of reset and while idle, `sdm_out` is 0, `done` is 0, `req_ready` is 1 and `txd_out` equals `enc_txd` in the same cycle.
- R2: A request is accepted on a rising clock edge with `req_valid`=1 and `req_ready`=1, and `req_fir` is captured at that edge. From the next cycle until the cycle after `done`, `req_ready` is 0 and `req_valid`/`req_fir` have no effect.
- R3: For LEAD cycles after acceptance (LEAD = floor(SD_LEAD_NS/CLK_NS)+1), `sdm_out` is 1 and `txd_out` is 0, whatever the mode.
- R4: In FIR mode (`req_fir`=1), `txd_out` goes to 1 after the LEAD cycles, and `sdm_out` stays 1 for SU further cycles before it falls. SU is the larger of floor(TXD_SETUP_NS/CLK_NS)+1 and PULSE−LEAD.
- R5: In SIR/MIR mode (`req_fir`=0), `txd_out` is 0 during every cycle of the sequence, including the setup and hold phases.
- R6: After `sdm_out` falls, `txd_out` keeps the mode value for HOLD cycles (HOLD = floor(TXD_HOLD_NS/CLK_NS)+1). It is then 0 in the done cycle.
- R7: Each high pulse on `sdm_out` lasts LEAD+SU cycles. This is at least PULSE = floor(SD_PULSE_NS/CLK_NS)+1 cycles and is strictly fewer than floor(SD_SHUTDOWN_NS/CLK_NS) cycles.
- R8: `done` is 1 for exactly one cycle, the cycle right after the hold phase, with `sdm_out`=0. In the next cycle `req_ready` is 1 and `txd_out` again follows `enc_txd`.
- R9: While a sequence runs, changes on `enc_txd` do not reach `txd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bandwidth request is present |
| req_fir | input | 1 | Requested bandwidth: 1 = FIR, 0 = SIR/MIR |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| enc_txd | input | 1 | Serial encoder transmit data, passed through when idle |
| sdm_out | output | 1 | Shutdown/mode line to the transceiver |
| txd_out | output | 1 | Transmit data line to the transceiver |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Two functions can meet in one cycle: the done pulse that closes a sequence, and the acceptance of a request that is already waiting. The second function also includes the return of the transmit line to the encoder. To provoke this, `req_valid` is held high across two whole sequences while `enc_txd` toggles. A behavioural model counts cycles from acceptance and predicts all four outputs on every clock. It is judged by whether the second acceptance lands in the first idle cycle after done. In that same cycle `txd_out` must equal the encoder bit. The cycle before it must show `done` with the line still owned.

// File: rtl/irseq_pkg.sv
package irseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_SD_HIGH     = 3'd1,
    ST_TXD_SETUP   = 3'd2,
    ST_SD_LOW_HOLD = 3'd3,
    ST_DONE        = 3'd4
  } seq_state_e;

  // Smallest whole number of cycles whose duration strictly exceeds ns.
  function automatic int unsigned cycles_exceeding(int unsigned ns, int unsigned period_ns);
    return (ns / period_ns) + 1;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Setup phase length: covers the txd setup and tops up the sd pulse width.
  function automatic int unsigned setup_len(int unsigned setup_c, int unsigned pulse_c,
                                            int unsigned lead_c);
    int unsigned top_up;
    top_up = (pulse_c > lead_c) ? (pulse_c - lead_c) : 1;
    return max_u(setup_c, top_up);
  endfunction

endpackage

// File: rtl/irseq_timer.sv
module irseq_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // The count never rises except through a load
  AST_TIMER_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> cnt_q <= $past(cnt_q)); // R7

endmodule

// File: rtl/irseq_fsm.sv
module irseq_fsm
  import irseq_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 3,
  parameter int unsigned SU_CYC   = 3,
  parameter int unsigned HOLD_CYC = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_fir,
  output logic       req_ready,
  output seq_state_e state,
  output logic       mode_fir,
  output logic       done
);

  localparam int unsigned MAXC = max_u(max_u(LEAD_CYC, SU_CYC), HOLD_CYC);
  localparam int unsigned TW   = $clog2(MAXC) + 1;

  seq_state_e state_q, state_n;
  logic       mode_q;
  logic       accept;
  logic       t_load;
  logic       t_expired;
  logic [TW-1:0] t_val;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:        if (req_valid) state_n = ST_SD_HIGH;
      ST_SD_HIGH:     if (t_expired) state_n = ST_TXD_SETUP;
      ST_TXD_SETUP:   if (t_expired) state_n = ST_SD_LOW_HOLD;
      ST_SD_LOW_HOLD: if (t_expired) state_n = ST_DONE;
      ST_DONE:        state_n = ST_IDLE;
      default:        state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      ST_SD_HIGH:     t_val = TW'(LEAD_CYC - 1);
      ST_TXD_SETUP:   t_val = TW'(SU_CYC - 1);
      ST_SD_LOW_HOLD: t_val = TW'(HOLD_CYC - 1);
      default:        t_val = '0;
    endcase
  end

  assign t_load = (state_n != state_q);

  irseq_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (accept) mode_q <= req_fir;
    end
  end

  assign state     = state_q;
  assign mode_fir  = mode_q;
  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> $stable(mode_q)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R8

endmodule

// File: rtl/irseq_linedrv.sv
module irseq_linedrv
  import irseq_pkg::*;
(
  input  seq_state_e state,
  input  logic       mode_fir,
  input  logic       enc_txd,
  output logic       sdm,
  output logic       txd
);

  always_comb begin
    sdm = 1'b0;
    txd = 1'b0;
    case (state)
      ST_IDLE:        txd = enc_txd;
      ST_SD_HIGH:     sdm = 1'b1;
      ST_TXD_SETUP:   begin sdm = 1'b1; txd = mode_fir; end
      ST_SD_LOW_HOLD: txd = mode_fir;
      ST_DONE:        ;
      default:        ;
    endcase
  end

endmodule

// File: rtl/irxcvr_bw_seq.sv
module irxcvr_bw_seq
  import irseq_pkg::*;
#(
  parameter int unsigned CLK_NS         = 10,
  parameter int unsigned SD_LEAD_NS     = 25,
  parameter int unsigned TXD_SETUP_NS   = 25,
  parameter int unsigned TXD_HOLD_NS    = 100,
  parameter int unsigned SD_PULSE_NS    = 50,
  parameter int unsigned SD_SHUTDOWN_NS = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_fir,
  output logic req_ready,
  input  logic enc_txd,
  output logic sdm_out,
  output logic txd_out,
  output logic done
);

  localparam int unsigned LEAD_CYC  = cycles_exceeding(SD_LEAD_NS, CLK_NS);
  localparam int unsigned SETUP_CYC = cycles_exceeding(TXD_SETUP_NS, CLK_NS);
  localparam int unsigned HOLD_CYC  = cycles_exceeding(TXD_HOLD_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = cycles_exceeding(SD_PULSE_NS, CLK_NS);
  localparam int unsigned SU_CYC    = setup_len(SETUP_CYC, PULSE_CYC, LEAD_CYC);
  localparam int unsigned LIMIT_CYC = SD_SHUTDOWN_NS / CLK_NS;
  localparam int unsigned RW        = $clog2(LIMIT_CYC + 1);

  seq_state_e state;
  logic       mode_fir;

  irseq_fsm #(
    .LEAD_CYC (LEAD_CYC),
    .SU_CYC   (SU_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fir   (req_fir),
    .req_ready (req_ready),
    .state     (state),
    .mode_fir  (mode_fir),
    .done      (done)
  );

  irseq_linedrv u_drv (
    .state    (state),
    .mode_fir (mode_fir),
    .enc_txd  (enc_txd),
    .sdm      (sdm_out),
    .txd      (txd_out)
  );

  // Length of the current high run on the shutdown/mode line
  logic [RW-1:0] sd_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      sd_run_q <= '0;
    else if (!sdm_out)                               sd_run_q <= '0;
    else if (sd_run_q != RW'(LIMIT_CYC))             sd_run_q <= sd_run_q + 1'b1;
  end

  AST_SD_RISE_TXD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdm_out) |-> !txd_out); // R3
  AST_TXD_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdm_out) |-> (txd_out == $past(txd_out))); // R6
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdm_out) |-> (sd_run_q >= RW'(PULSE_CYC))); // R7
  AST_PULSE_BELOW_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sd_run_q < RW'(LIMIT_CYC)); // R7
  AST_DONE_SD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sdm_out && !txd_out)); // R8
  AST_SIR_TXD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mode_fir) |-> !txd_out); // R5

endmodule

// File: tb/irxcvr_bw_seq_test.sv
module irxcvr_bw_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEAD  = 25 / CLK_PERIOD + 1;
  localparam int SETUP = 25 / CLK_PERIOD + 1;
  localparam int PULSE = 50 / CLK_PERIOD + 1;
  localparam int SU    = (SETUP > PULSE - LEAD) ? SETUP : PULSE - LEAD;
  localparam int HOLD  = 100 / CLK_PERIOD + 1;
  localparam int TOTAL = LEAD + SU + HOLD + 1;
  localparam int LIMIT = 400000 / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_fir = 1'b0;
  logic enc_txd = 1'b0;
  logic req_ready, sdm_out, txd_out, done;

  int vectors = 0;
  int miscompares = 0;
  int pos = -1;
  logic mode_m = 1'b0;
  int sd_run = 0;
  int cycles = 0;
  logic finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  irxcvr_bw_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fir(req_fir),
    .req_ready(req_ready), .enc_txd(enc_txd), .sdm_out(sdm_out),
    .txd_out(txd_out), .done(done)
  );

  // Reference model: cycle position since acceptance
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) pos = -1;
    else if (pos < 0) begin
      if (req_valid) begin pos = 0; mode_m = req_fir; end
    end else begin
      pos = pos + 1;
      if (pos == TOTAL) pos = -1;
    end
  end

  // Encoder activity, also while busy (R9)
  initial forever begin
    @(negedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    enc_txd = lfsr[0];
  end

  // Compare every clock
  always @(negedge clk) begin
    logic e_sd, e_txd, e_done, e_rdy;
    string tag;
    if (!finished) begin
      e_sd = 0; e_txd = 0; e_done = 0; e_rdy = 0;
      if (!rst_n || pos < 0) begin
        e_rdy = 1; e_txd = enc_txd; tag = "R1/R8";
      end else if (pos < LEAD) begin
        e_sd = 1; tag = "R3/R9";
      end else if (pos < LEAD + SU) begin
        e_sd = 1; e_txd = mode_m; tag = mode_m ? "R4/R9" : "R5/R9";
      end else if (pos < LEAD + SU + HOLD) begin
        e_txd = mode_m; tag = mode_m ? "R6/R9" : "R5/R6";
      end else begin
        e_done = 1; tag = "R8";
      end
      if (pos >= 0 && rst_n) tag = {tag, "/R2"};
      vectors++;
      if (sdm_out !== e_sd || txd_out !== e_txd || done !== e_done || req_ready !== e_rdy) begin
        miscompares++;
        $display("FAIL %s pos=%0d sd=%b exp %b txd=%b exp %b done=%b exp %b rdy=%b exp %b",
                 tag, pos, sdm_out, e_sd, txd_out, e_txd, done, e_done, req_ready, e_rdy);
      end
      // R7: pulse width on each falling edge of the line
      if (sdm_out === 1'b1) sd_run++;
      else begin
        if (sd_run != 0) begin
          vectors++;
          if (sd_run != LEAD + SU || sd_run < PULSE || sd_run >= LIMIT) begin
            miscompares++;
            $display("FAIL R7 sd pulse=%0d expected %0d", sd_run, LEAD + SU);
          end
        end
        sd_run = 0;
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic send(input logic fir);
    req_valid = 1; req_fir = fir;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 0;
    req_fir = ~fir; // R2: change ignored while busy
    idle_cycles(TOTAL + 2);
  endtask

  task automatic summary;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    idle_cycles(4);             // R1: reset state compared each cycle
    rst_n = 1;
    idle_cycles(5);             // R1: pass-through while idle
    send(1'b1);                 // R4, R6, R7, R8, R9
    send(1'b0);                 // R5
    req_valid = 1; req_fir = 1; // R2, R8: waiting request served back-to-back
    idle_cycles(TOTAL + 1);
    req_fir = 0;
    idle_cycles(TOTAL + 2);
    req_valid = 0;
    idle_cycles(TOTAL + 2);
    send(1'b0);
    send(1'b1);
    idle_cycles(5);
    summary();
  end

  initial begin
    wait (cycles > 50000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule